// File: doc/BRIEF.md
# Column-Ordered Carry-Less Digit Multiplier

This block multiplies two binary polynomials with coefficients in GF(2). Each operand is held as `N` digits of `BW` bits in a small word-addressed memory. The block reads those digits through its own address ports. Coefficient sums are XOR and coefficient products are AND, so no carry ever moves between bit positions.

The product is formed one column at a time, from the least significant column upward. Column `k` collects every digit product whose two digit indices add up to `k`. Because of this ordering, only a lower and an upper accumulator word of `BW` bits each are ever live, whatever the value of `N`. When a column closes, its lower word leaves through the result write port as digit `k`. The upper word then moves down to seed the next column. The last of the `2N` result digits is the word left over after the final column.

The host loads both operand memories, pulses `start` and waits for `done`. Each operand memory answers one cycle after the block presents an address.

Top module: `gf2_colmul`

## Requirements
- R1: The `2N` result digits, taken together with digit 0 least significant, equal the carry-less product of A and B: result bit `n` is the XOR over all `i` of `A[i] AND B[n-i]`. Digit `d` of an operand covers operand bits `d*BW` to `d*BW+BW-1`.
- R2: Every operation writes each result index `0 .. 2N-1` exactly once, in ascending order. Each write is a one-cycle pulse on `r_we`.
- R3: The digit pairs are read column by column. In the `m`-th cycle after `start` is sampled (first such cycle `m=0`, up to `m=N*N-1`), `a_addr + b_addr` equals the column of the `m`-th pair, and both addresses stay below `N`. Each column `k` is read with `a_addr` running upward from `max(0,k-N+1)` to `min(k,N-1)`.
- R4: Result digit `2N-1` is written in the cycle directly after result digit `2N-2`.
- R5: `done` is high for exactly one cycle. That cycle comes right after the write of digit `2N-1` and lies `N*N+3` cycles after the clock edge that samples `start`.
- R6: `busy` is high from the edge that accepts `start` through the `done` cycle. A `start` that arrives while `busy` is high has no effect on the addresses, the written digits or the timing.
- R7: After reset, `busy`, `done` and `r_we` are low.
- R8: A new operation that starts after `busy` falls yields a result that does not depend on the previous operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; sampled only while idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| a_addr | output | $clog2(N) | Digit index read from operand A memory |
| a_rdata | input | BW | Digit of A, one cycle after `a_addr` |
| b_addr | output | $clog2(N) | Digit index read from operand B memory |
| b_rdata | input | BW | Digit of B, one cycle after `b_addr` |
| r_we | output | 1 | Result digit write strobe |
| r_addr | output | $clog2(2N) | Index of the result digit being written |
| r_wdata | output | BW | Result digit value |

## Verification
The hardest case to reach is one where the high half of a column's product changes the digit written for the following column. That happens only when both the upper accumulator word and the final leftover digit are non-zero. The stimulus therefore multiplies operands whose top bits are set (all ones, and the single highest coefficient squared), so that the bits land in digit `2N-1`. A second hard case is a `start` that arrives in the middle of a run. The bench raises it several cycles into an operation and then requires the address sequence, the digits and the latency to match an undisturbed run.

// File: rtl/gf2cm_pkg.sv
package gf2cm_pkg;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_WAIT} sq_state_t;

  // first A-digit index contributing to column k
  function automatic int col_first(input int k, input int n);
    return (k >= n) ? (k - n + 1) : 0;
  endfunction

  // last A-digit index contributing to column k
  function automatic int col_final(input int k, input int n);
    return (k < n) ? k : (n - 1);
  endfunction

endpackage

// File: rtl/gf2cm_sched.sv
module gf2cm_sched #(
  parameter int N  = 4,
  parameter int AW = $clog2(N),
  parameter int KW = $clog2(2*N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fin,
  output logic          busy,
  output logic          issue_v,
  output logic          issue_last,
  output logic [KW-1:0] issue_col,
  output logic [AW-1:0] a_idx,
  output logic [AW-1:0] b_idx
);
  import gf2cm_pkg::*;

  localparam int LAST_COL = 2*N - 2;

  sq_state_t     state;
  logic [KW-1:0] k_q;
  logic [AW-1:0] i_q;

  always_comb begin
    busy       = (state != SQ_IDLE);
    issue_v    = (state == SQ_RUN);
    issue_last = issue_v && (int'(i_q) == col_final(int'(k_q), N));
    issue_col  = k_q;
    a_idx      = i_q;
    b_idx      = AW'(int'(k_q) - int'(i_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      k_q   <= '0;
      i_q   <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          state <= SQ_RUN;
          k_q   <= '0;
          i_q   <= '0;
        end
        SQ_RUN: begin
          if (issue_last) begin
            if (int'(k_q) == LAST_COL) begin
              state <= SQ_WAIT;
            end else begin
              k_q <= k_q + 1'b1;
              i_q <= AW'(col_first(int'(k_q) + 1, N));
            end
          end else begin
            i_q <= i_q + 1'b1;
          end
        end
        SQ_WAIT: if (fin) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R3: every issued pair lies inside the operand memories
  p_pair_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> (int'(a_idx) < N && int'(b_idx) < N));

  // R6: a start during an operation does not rewind the walk
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !(k_q == '0 && i_q == '0));

endmodule

// File: rtl/gf2cm_digit_mul.sv
module gf2cm_digit_mul #(
  parameter int BW = 64
) (
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [BW-1:0] prod_lo,
  output logic [BW-1:0] prod_hi
);
  // shift-and-XOR form of the carry-less digit product
  function automatic logic [2*BW-1:0] clmul(input logic [BW-1:0] x,
                                            input logic [BW-1:0] y);
    logic [2*BW-1:0] acc;
    acc = '0;
    for (int s = 0; s < BW; s++) begin
      if (x[s]) acc = acc ^ ({{BW{1'b0}}, y} << s);
    end
    return acc;
  endfunction

  logic [2*BW-1:0] full;

  always_comb begin
    full    = clmul(a, b);
    prod_lo = full[BW-1:0];
    prod_hi = full[2*BW-1:BW];
  end

endmodule

// File: rtl/gf2cm_accum.sv
module gf2cm_accum #(
  parameter int N  = 4,
  parameter int BW = 64,
  parameter int KW = $clog2(2*N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          in_v,
  input  logic          in_last,
  input  logic [KW-1:0] in_col,
  input  logic [BW-1:0] prod_lo,
  input  logic [BW-1:0] prod_hi,
  output logic          r_we,
  output logic [KW-1:0] r_addr,
  output logic [BW-1:0] r_wdata,
  output logic          done
);
  localparam int LAST_COL = 2*N - 2;
  localparam int TAIL_IDX = 2*N - 1;

  logic          s1_v, s1_last;
  logic [KW-1:0] s1_col;
  logic [BW-1:0] acc_lo, acc_hi;
  logic          tail_q, tailwr_q;
  logic          col_close;

  assign col_close = s1_v && s1_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_last  <= 1'b0;
      s1_col   <= '0;
      acc_lo   <= '0;
      acc_hi   <= '0;
      tail_q   <= 1'b0;
      tailwr_q <= 1'b0;
      r_we     <= 1'b0;
      r_addr   <= '0;
      r_wdata  <= '0;
      done     <= 1'b0;
    end else begin
      s1_v     <= in_v;
      s1_last  <= in_last;
      s1_col   <= in_col;
      r_we     <= 1'b0;
      done     <= tailwr_q;
      tailwr_q <= tail_q;
      tail_q   <= 1'b0;
      if (clear) begin
        acc_lo <= '0;
        acc_hi <= '0;
      end else if (col_close) begin
        r_we    <= 1'b1;
        r_addr  <= s1_col;
        r_wdata <= acc_lo ^ prod_lo;
        acc_lo  <= acc_hi ^ prod_hi;
        acc_hi  <= '0;
        tail_q  <= (int'(s1_col) == LAST_COL);
      end else if (s1_v) begin
        acc_lo <= acc_lo ^ prod_lo;
        acc_hi <= acc_hi ^ prod_hi;
      end else if (tail_q) begin
        r_we    <= 1'b1;
        r_addr  <= KW'(TAIL_IDX);
        r_wdata <= acc_lo;
      end
    end
  end

  // checker counter: next result index expected at the write port
  logic [KW:0] chk_next;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_next <= '0;
    else if (clear)  chk_next <= '0;
    else if (r_we)   chk_next <= chk_next + 1'b1;
  end

  // R2: digits leave in ascending order, each once
  p_digit_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    r_we |-> (int'(r_addr) == int'(chk_next)));

  // R4: leftover digit follows the last full column at once
  p_tail_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_we && int'(r_addr) == LAST_COL) |=> (r_we && int'(r_addr) == TAIL_IDX));

  // R5: done comes right after the final write
  p_done_after_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(r_we) && int'($past(r_addr)) == TAIL_IDX));

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/gf2_colmul.sv
module gf2_colmul #(
  parameter int N  = 4,
  parameter int BW = 64,
  localparam int AW = $clog2(N),
  localparam int KW = $clog2(2*N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] a_addr,
  input  logic [BW-1:0] a_rdata,
  output logic [AW-1:0] b_addr,
  input  logic [BW-1:0] b_rdata,
  output logic          r_we,
  output logic [KW-1:0] r_addr,
  output logic [BW-1:0] r_wdata
);
  logic          issue_v, issue_last;
  logic [KW-1:0] issue_col;
  logic [BW-1:0] prod_lo, prod_hi;
  logic          accept;

  assign accept = start && !busy;

  gf2cm_sched #(.N(N), .AW(AW), .KW(KW)) u_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .fin(done), .busy(busy),
    .issue_v(issue_v), .issue_last(issue_last), .issue_col(issue_col),
    .a_idx(a_addr), .b_idx(b_addr)
  );

  gf2cm_digit_mul #(.BW(BW)) u_dmul (
    .a(a_rdata), .b(b_rdata), .prod_lo(prod_lo), .prod_hi(prod_hi)
  );

  gf2cm_accum #(.N(N), .BW(BW), .KW(KW)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .in_v(issue_v), .in_last(issue_last), .in_col(issue_col),
    .prod_lo(prod_lo), .prod_hi(prod_hi),
    .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .done(done)
  );

  // R6: busy holds from an accepted start until done has been seen
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: tb/gf2_colmul_bench.sv
module gf2_colmul_bench;
  localparam int N  = 4;
  localparam int BW = 64;
  localparam int AW = $clog2(N);
  localparam int KW = $clog2(2*N);
  localparam int W  = N*BW;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, r_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [BW-1:0] a_rdata, b_rdata, r_wdata;
  logic [KW-1:0] r_addr;

  logic [BW-1:0] mem_a [N];
  logic [BW-1:0] mem_b [N];

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  typedef struct { int idx; logic [BW-1:0] val; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    a_rdata <= mem_a[a_addr];
    b_rdata <= mem_b[b_addr];
    cycles  <= cycles + 1;
  end

  gf2_colmul #(.N(N), .BW(BW)) u_gf2_colmul (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .a_addr(a_addr), .a_rdata(a_rdata), .b_addr(b_addr), .b_rdata(b_rdata),
    .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bit-serial reference product, written from the definition
  function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a,
                                               input logic [W-1:0] b);
    logic [2*W-1:0] r;
    r = '0;
    for (int n = 0; n < 2*W - 1; n++) begin
      logic bitv;
      bitv = 1'b0;
      for (int i = 0; i < W; i++) begin
        if (n - i >= 0 && n - i < W) bitv = bitv ^ (a[i] & b[n-i]);
      end
      r[n] = bitv;
    end
    return r;
  endfunction

  // monitor: compares every written digit against the scoreboard
  always @(negedge clk) begin
    if (rst_n && r_we) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected write", BW'(r_addr), '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(int'(r_addr) == it.idx, "R2", "digit index",
              BW'(r_addr), BW'(it.idx));
        check(r_wdata == it.val, (it.idx == 2*N-1) ? "R4" : "R1",
              "digit value", r_wdata, it.val);
      end
    end
  end

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit poke_start, input string tag);
    logic [2*W-1:0] prod;
    int seq[$];
    int cnt;
    for (int d = 0; d < N; d++) begin
      mem_a[d] = a[d*BW +: BW];
      mem_b[d] = b[d*BW +: BW];
    end
    prod = ref_prod(a, b);
    for (int d = 0; d < 2*N; d++) sb.push_back('{d, prod[d*BW +: BW]});
    for (int k = 0; k <= 2*N-2; k++) begin
      for (int i = (k >= N ? k-N+1 : 0); i <= (k < N ? k : N-1); i++)
        seq.push_back(k);
    end
    @(negedge clk);
    start = 1'b1;
    cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      start = (poke_start && cnt == 5) ? 1'b1 : 1'b0;
      if (cnt <= N*N) begin
        check(int'(a_addr) + int'(b_addr) == seq[cnt-1] &&
              int'(a_addr) < N && int'(b_addr) < N, "R3",
              {tag, " pair column"}, BW'(int'(a_addr) + int'(b_addr)),
              BW'(seq[cnt-1]));
      end
      if (cnt == 2) check(busy, "R6", {tag, " busy during run"}, BW'(busy), 1);
      if (done || cnt > 200) break;
    end
    check(cnt == N*N + 4, "R5", {tag, " done latency"}, BW'(cnt), BW'(N*N+4));
    @(negedge clk);
    check(!done, "R5", {tag, " done single cycle"}, BW'(done), 0);
    check(!busy, "R6", {tag, " busy released"}, BW'(busy), 0);
    check(sb.size() == 0, "R2", {tag, " all digits written"},
          BW'(sb.size()), 0);
    sb.delete();
  endtask

  initial begin
    logic [W-1:0] ra, rb;
    for (int d = 0; d < N; d++) begin
      mem_a[d] = '0;
      mem_b[d] = '0;
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !r_we, "R7", "reset outputs",
          BW'({busy, done, r_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op('0, '0, 1'b0, "zero");
    run_op({W{1'b1}}, {W{1'b1}}, 1'b0, "ones");
    run_op(W'(1) << (W-1), W'(1) << (W-1), 1'b0, "top bits");
    for (int t = 0; t < 3; t++) begin
      for (int d = 0; d < N*BW/32; d++) begin
        ra[d*32 +: 32] = $urandom;
        rb[d*32 +: 32] = $urandom;
      end
      run_op(ra, rb, 1'b0, "R8 random");
    end
    run_op(W'(1), rb, 1'b0, "identity");
    run_op(ra, {W{1'b1}}, 1'b1, "R6 restart poke");
    run_op(rb, ra, 1'b0, "R8 after poke");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule